// File: doc/BRIEF.md
# DMA Channel Transfer Counter Unit

This block holds the counting state of one DMA channel: a 32-bit transfer count and a 32-bit block-size register. Each time the surrounding controller reports a finished data transfer, the transfer count steps down by the number of bytes moved. When the count reaches zero the unit raises a terminate pulse and drops its channel-active flag. A count that is already zero means the channel is free-running: transfers are not counted and nothing terminates.

The block-size register is split in two halves. The upper half holds the programmed block or repeat length, and hardware never alters it. The lower half counts transfers down in block and repeat modes. Where it would reach zero it reloads from the upper half instead, and it raises a block-boundary pulse so the controller can close a block or restart a repeat area. A CPU register port writes either register as a whole or one 16-bit half at a time. A CPU write that lands in the same cycle as a hardware update always wins the stored value. The terminate event is still reported when the final step of the count coincides with a CPU write.

Top module: `dma_xfer_count_unit`

## Requirements
- R1: On `xfer_done` with a nonzero count, the transfer count drops by the step for `xfer_size`: 00 (byte) steps 1, 01 (word) steps 2, 10 (longword) and the spare code 11 step 4.
- R2: When the transfer count is zero, `xfer_done` leaves it at zero and raises no terminate pulse.
- R3: A CPU write to the count register (`cpu_sel`=0) stores the written lanes even when a hardware step lands in the same cycle. `cpu_wr_lane` bit 0 selects bits 15:0 and bit 1 selects bits 31:16. An unwritten half takes the value the hardware step produced.
- R4: A step from a nonzero count not above the step size stores zero and pulses `term_pulse` high for exactly the following cycle. The pulse also fires when a CPU write stores its own value in that cycle.
- R5: Bits 31:16 of the block-size register change only through a CPU write with `cpu_sel`=1 and lane bit 1 set.
- R6: In block mode (`chan_mode`=01) and repeat mode (10), each `xfer_done` lowers bits 15:0 of the block-size register by 1.
- R7: In block or repeat mode, `xfer_done` with the lower half at 1 or 0 loads the upper half into the lower half and pulses `blk_pulse` for one cycle. A CPU write to the lower half in that cycle still wins the stored value, and the pulse still fires.
- R8: In normal mode (`chan_mode`=00, and the spare code 11), `xfer_done` leaves the block-size register unchanged and raises no block pulse.
- R9: `chan_active` is set by a CPU count write that leaves the count nonzero and cleared by one that leaves it zero. A terminate event clears it and overrides a write in the same cycle.
- R10: A synchronous active-low reset clears both registers, `chan_active`, `term_pulse` and `blk_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_done | input | 1 | One data transfer finished this cycle |
| xfer_size | input | 2 | Size of the finished transfer (00 byte, 01 word, 10/11 longword) |
| chan_mode | input | 2 | 00 normal, 01 block, 10 repeat, 11 treated as normal |
| cpu_wr_en | input | 1 | CPU register write strobe |
| cpu_sel | input | 1 | 0 selects transfer count, 1 selects block size |
| cpu_wr_lane | input | 2 | Half-word enables: bit 0 low half, bit 1 high half |
| cpu_wdata | input | 32 | CPU write data |
| tcnt_q | output | 32 | Current transfer count |
| bsize_q | output | 32 | Current block-size register |
| chan_active | output | 1 | Channel active flag |
| term_pulse | output | 1 | One-cycle pulse after the count reaches zero |
| blk_pulse | output | 1 | One-cycle pulse after the block counter reloads |

## Verification
The bench drives the count through every step size down into a final step that overshoots. An implementation that subtracted blindly would wrap to a huge value and never terminate. A transfer at zero count shows whether a design wrongly counts or fires on a free-running channel. Same-cycle collisions of a CPU write with the final step, a half-word write and a reload check three faults: a CPU write that loses to hardware, a mixed half taken from the stale value, and a terminate or boundary pulse swallowed by the write. A lower block counter of zero, writes to the upper half while counting, and the normal and spare modes catch reloads that are missed, doubled or fired in a mode that does not count.

// File: rtl/xcnt_pkg.sv
// Package: shared encodings for the DMA transfer counter unit.
// Assumes the transfer-size and channel-mode codes below are fixed by the
// surrounding controller.
package xcnt_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_SPARE = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_BLOCK  = 2'b01,
        MODE_REPEAT = 2'b10,
        MODE_SPARE  = 2'b11
    } chan_mode_e;

    localparam int LANES = 2;

endpackage

// File: rtl/xcnt_lane_merge.sv
// Module: per-lane write merge. Each lane enabled by the write takes the CPU
// data; every other lane keeps the hardware-updated value.
// Assumes REG_W divides evenly by LANES.
module xcnt_lane_merge #(
    parameter int REG_W = 32,
    parameter int LANES = 2
) (
    input  logic             wr_en,
    input  logic [LANES-1:0] wr_lanes,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] hw_val,
    output logic [REG_W-1:0] merged
);
    localparam int LANE_W = REG_W / LANES;

    genvar ln;
    generate
        for (ln = 0; ln < LANES; ln++) begin : g_lane
            // choose CPU or hardware data for this lane
            assign merged[ln*LANE_W +: LANE_W] = (wr_en && wr_lanes[ln])
                ? wr_data[ln*LANE_W +: LANE_W]
                : hw_val[ln*LANE_W +: LANE_W];
        end
    endgenerate
endmodule

// File: rtl/xcnt_count_reg.sv
// Module: transfer count register. Steps down by the byte size of each finished
// transfer and flags the final step. A zero count is free-running and never
// steps. A CPU write merges over the stepped value.
// Assumes at most one transfer completes per cycle.
module xcnt_count_reg
    import xcnt_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic [1:0]       size_code,
    input  logic             wr_en,
    input  logic [LANES-1:0] wr_lanes,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] cnt_q,
    output logic [REG_W-1:0] cnt_next,
    output logic             final_hit,
    output logic             term_q
);
    logic [REG_W-1:0] step_amt;
    logic [REG_W-1:0] hw_next;

    // decode the transfer size into a byte step
    always_comb begin
        case (size_code)
            SZ_BYTE: step_amt = REG_W'(1);
            SZ_WORD: step_amt = REG_W'(2);
            default: step_amt = REG_W'(4);
        endcase
    end

    // hardware step: hold at zero, saturate the final step to zero
    always_comb begin
        hw_next   = cnt_q;
        final_hit = 1'b0;
        if (step_en && (cnt_q != '0)) begin
            if (cnt_q <= step_amt) begin
                hw_next   = '0;
                final_hit = 1'b1;
            end else begin
                hw_next = cnt_q - step_amt;
            end
        end
    end

    xcnt_lane_merge #(.REG_W(REG_W), .LANES(LANES)) u_merge (
        .wr_en    (wr_en),
        .wr_lanes (wr_lanes),
        .wr_data  (wr_data),
        .hw_val   (hw_next),
        .merged   (cnt_next)
    );

    // store the count and register the terminate pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            term_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_next;
            term_q <= final_hit;
        end
    end
endmodule

// File: rtl/xcnt_block_reg.sv
// Module: block-size register. The upper half is a programmed length that only
// the CPU changes. The lower half counts down in counting modes and reloads from
// the upper half where it would reach zero.
// Assumes the counting-mode decision is made by the parent.
module xcnt_block_reg
    import xcnt_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             mode_counts,
    input  logic             wr_en,
    input  logic [LANES-1:0] wr_lanes,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] blk_q,
    output logic             blk_pulse_q
);
    localparam int HALF_W = REG_W / 2;

    logic [HALF_W-1:0] lo_now;
    logic [HALF_W-1:0] hi_now;
    logic [HALF_W-1:0] lo_hw;
    logic              reload_hit;
    logic [REG_W-1:0]  hw_next;
    logic [REG_W-1:0]  blk_next;

    assign lo_now = blk_q[HALF_W-1:0];
    assign hi_now = blk_q[REG_W-1:HALF_W];

    // lower-half countdown with reload instead of zero
    always_comb begin
        lo_hw      = lo_now;
        reload_hit = 1'b0;
        if (step_en && mode_counts) begin
            if (lo_now <= HALF_W'(1)) begin
                lo_hw      = hi_now;
                reload_hit = 1'b1;
            end else begin
                lo_hw = lo_now - HALF_W'(1);
            end
        end
    end

    assign hw_next = {hi_now, lo_hw};

    xcnt_lane_merge #(.REG_W(REG_W), .LANES(LANES)) u_merge (
        .wr_en    (wr_en),
        .wr_lanes (wr_lanes),
        .wr_data  (wr_data),
        .hw_val   (hw_next),
        .merged   (blk_next)
    );

    // store the register and register the boundary pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q       <= '0;
            blk_pulse_q <= 1'b0;
        end else begin
            blk_q       <= blk_next;
            blk_pulse_q <= reload_hit;
        end
    end
endmodule

// File: rtl/xcnt_active_ctl.sv
// Module: channel-active flag. A CPU count write arms or disarms the flag by the
// value it leaves behind. A terminate event clears it and overrides the write.
// Assumes next_nonzero reflects the value being stored this cycle.
module xcnt_active_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_wr,
    input  logic next_nonzero,
    input  logic final_hit,
    output logic active_q
);
    // update the flag; termination has the last word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else if (final_hit) begin
            active_q <= 1'b0;
        end else if (cnt_wr) begin
            active_q <= next_nonzero;
        end
    end
endmodule

// File: rtl/dma_xfer_count_unit.sv
// Module: top of the per-channel DMA transfer counter unit. It routes the CPU
// port to the count or block-size register, decodes the counting modes and
// drives the active flag.
// Assumes xfer_done is a single-cycle strobe per finished transfer.
module dma_xfer_count_unit
    import xcnt_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_done,
    input  logic [1:0]       xfer_size,
    input  logic [1:0]       chan_mode,
    input  logic             cpu_wr_en,
    input  logic             cpu_sel,
    input  logic [1:0]       cpu_wr_lane,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] tcnt_q,
    output logic [REG_W-1:0] bsize_q,
    output logic             chan_active,
    output logic             term_pulse,
    output logic             blk_pulse
);
    logic             cnt_wr;
    logic             blk_wr;
    logic             mode_counts;
    logic [REG_W-1:0] cnt_next;
    logic             final_hit;

    assign cnt_wr      = cpu_wr_en && !cpu_sel;
    assign blk_wr      = cpu_wr_en && cpu_sel;
    assign mode_counts = (chan_mode == MODE_BLOCK) || (chan_mode == MODE_REPEAT);

    xcnt_count_reg #(.REG_W(REG_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (xfer_done),
        .size_code (xfer_size),
        .wr_en     (cnt_wr),
        .wr_lanes  (cpu_wr_lane),
        .wr_data   (cpu_wdata),
        .cnt_q     (tcnt_q),
        .cnt_next  (cnt_next),
        .final_hit (final_hit),
        .term_q    (term_pulse)
    );

    xcnt_block_reg #(.REG_W(REG_W)) u_block (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_en     (xfer_done),
        .mode_counts (mode_counts),
        .wr_en       (blk_wr),
        .wr_lanes    (cpu_wr_lane),
        .wr_data     (cpu_wdata),
        .blk_q       (bsize_q),
        .blk_pulse_q (blk_pulse)
    );

    xcnt_active_ctl u_active (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_wr       (cnt_wr),
        .next_nonzero (cnt_next != '0),
        .final_hit    (final_hit),
        .active_q     (chan_active)
    );
endmodule

// File: rtl/xcnt_checker.sv
// Module: property checker for dma_xfer_count_unit, attached by bind.
// Watches ports only; assumes reset is held for at least two cycles.
module xcnt_checker #(
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_done,
    input logic [1:0]       xfer_size,
    input logic [1:0]       chan_mode,
    input logic             cpu_wr_en,
    input logic             cpu_sel,
    input logic [1:0]       cpu_wr_lane,
    input logic [REG_W-1:0] cpu_wdata,
    input logic [REG_W-1:0] tcnt_q,
    input logic [REG_W-1:0] bsize_q,
    input logic             chan_active,
    input logic             term_pulse,
    input logic             blk_pulse
);
    localparam int HALF_W = REG_W / 2;

    logic [REG_W-1:0] step_w;
    logic             cnt_wr_c;
    logic             blk_wr_c;
    logic             idle_mode;

    assign step_w    = (xfer_size == 2'b00) ? REG_W'(1) :
                       (xfer_size == 2'b01) ? REG_W'(2) : REG_W'(4);
    assign cnt_wr_c  = cpu_wr_en && !cpu_sel;
    assign blk_wr_c  = cpu_wr_en && cpu_sel;
    assign idle_mode = (chan_mode == 2'b00) || (chan_mode == 2'b11);

    a_r1_step_by_size: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !cnt_wr_c && (tcnt_q > step_w))
        |=> (tcnt_q == $past(tcnt_q) - $past(step_w)));

    a_r2_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((tcnt_q == '0) && !cnt_wr_c) |=> ((tcnt_q == '0) && !term_pulse));

    a_r3_cpu_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr_c && (cpu_wr_lane == 2'b11)) |=> (tcnt_q == $past(cpu_wdata)));

    a_r4_final_terminates: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && (tcnt_q != '0) && (tcnt_q <= step_w)) |=> term_pulse);

    a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !(blk_wr_c && cpu_wr_lane[1]) |=> $stable(bsize_q[REG_W-1:HALF_W]));

    a_r7_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_mode && xfer_done && !blk_wr_c && (bsize_q[HALF_W-1:0] <= HALF_W'(1)))
        |=> (blk_pulse && (bsize_q[HALF_W-1:0] == bsize_q[REG_W-1:HALF_W])));

    a_r8_normal_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_mode && !blk_wr_c) |=> ($stable(bsize_q) && !blk_pulse));

    a_r9_term_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
        term_pulse |-> !chan_active);
endmodule

bind dma_xfer_count_unit xcnt_checker #(.REG_W(REG_W)) u_xcnt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_done   (xfer_done),
    .xfer_size   (xfer_size),
    .chan_mode   (chan_mode),
    .cpu_wr_en   (cpu_wr_en),
    .cpu_sel     (cpu_sel),
    .cpu_wr_lane (cpu_wr_lane),
    .cpu_wdata   (cpu_wdata),
    .tcnt_q      (tcnt_q),
    .bsize_q     (bsize_q),
    .chan_active (chan_active),
    .term_pulse  (term_pulse),
    .blk_pulse   (blk_pulse)
);

// File: tb/tb_dma_xfer_count_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies one cycle of stimulus, predicts the
// register state from the requirements and queues it; the monitor compares on
// the falling edge.
module tb_dma_xfer_count_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_done = 1'b0;
    logic [1:0]  xfer_size = 2'b00;
    logic [1:0]  chan_mode = 2'b00;
    logic        cpu_wr_en = 1'b0;
    logic        cpu_sel = 1'b0;
    logic [1:0]  cpu_wr_lane = 2'b00;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] tcnt_q;
    logic [31:0] bsize_q;
    logic        chan_active;
    logic        term_pulse;
    logic        blk_pulse;

    typedef struct {
        logic [31:0] t;
        logic [31:0] b;
        logic        term;
        logic        blk;
        logic        act;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] m_t = '0;
    logic [31:0] m_b = '0;
    logic        m_act = 1'b0;
    bit          done_flag = 1'b0;

    always #2.5 clk = ~clk;

    dma_xfer_count_unit dut (
        .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .xfer_size(xfer_size),
        .chan_mode(chan_mode), .cpu_wr_en(cpu_wr_en), .cpu_sel(cpu_sel),
        .cpu_wr_lane(cpu_wr_lane), .cpu_wdata(cpu_wdata), .tcnt_q(tcnt_q),
        .bsize_q(bsize_q), .chan_active(chan_active), .term_pulse(term_pulse),
        .blk_pulse(blk_pulse)
    );

    function automatic logic [31:0] lane_mix(input logic [1:0] ln, input logic [31:0] wd,
                                             input logic [31:0] hw);
        logic [31:0] r;
        r = hw;
        if (ln[0]) r[15:0]  = wd[15:0];
        if (ln[1]) r[31:16] = wd[31:16];
        return r;
    endfunction

    task automatic one_cycle(input logic d, input logic [1:0] sz, input logic [1:0] md,
                             input logic w, input logic sel, input logic [1:0] ln,
                             input logic [31:0] wd, input string tag);
        exp_t e;
        logic [31:0] st;
        logic [31:0] hw_t;
        logic [31:0] hw_b;
        logic        term;
        logic        blk;
        xfer_done = d; xfer_size = sz; chan_mode = md;
        cpu_wr_en = w; cpu_sel = sel; cpu_wr_lane = ln; cpu_wdata = wd;
        // prediction from the requirements
        st = (sz == 2'b00) ? 32'd1 : (sz == 2'b01) ? 32'd2 : 32'd4;
        hw_t = m_t; term = 1'b0;
        if (d && m_t != 0) begin
            if (m_t <= st) begin hw_t = 0; term = 1'b1; end
            else hw_t = m_t - st;
        end
        hw_b = m_b; blk = 1'b0;
        if (d && (md == 2'b01 || md == 2'b10)) begin
            if (m_b[15:0] <= 16'd1) begin hw_b[15:0] = m_b[31:16]; blk = 1'b1; end
            else hw_b[15:0] = m_b[15:0] - 16'd1;
        end
        if (w && !sel) hw_t = lane_mix(ln, wd, hw_t);
        if (w && sel)  hw_b = lane_mix(ln, wd, hw_b);
        if (term) m_act = 1'b0;
        else if (w && !sel) m_act = (hw_t != 0);
        m_t = hw_t; m_b = hw_b;
        @(posedge clk);
        #1;
        e.t = m_t; e.b = m_b; e.term = term; e.blk = blk; e.act = m_act; e.tag = tag;
        exp_q.push_back(e);
        xfer_done = 1'b0; cpu_wr_en = 1'b0; cpu_wr_lane = 2'b00;
    endtask

    task automatic apply_reset();
        exp_t e;
        rst_n = 1'b0; xfer_done = 1'b0; cpu_wr_en = 1'b0;
        @(posedge clk);
        #1;
        m_t = '0; m_b = '0; m_act = 1'b0;
        e.t = '0; e.b = '0; e.term = 1'b0; e.blk = 1'b0; e.act = 1'b0; e.tag = "R10";
        exp_q.push_back(e);
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic cmp(input string tag, input string fld, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
        end
    endtask

    // monitor: compare one queued prediction per falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            cmp(e.tag, "tcnt", tcnt_q, e.t);
            cmp(e.tag, "bsize", bsize_q, e.b);
            cmp(e.tag, "term", {31'd0, term_pulse}, {31'd0, e.term});
            cmp(e.tag, "blk", {31'd0, blk_pulse}, {31'd0, e.blk});
            cmp(e.tag, "active", {31'd0, chan_active}, {31'd0, e.act});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        apply_reset();                                                  // R10
        one_cycle(0, 2'b00, 2'b00, 1, 0, 2'b11, 32'd10, "R9");          // arm, count 10
        one_cycle(1, 2'b00, 2'b00, 0, 0, 2'b00, 0, "R1");               // byte -> 9
        one_cycle(1, 2'b01, 2'b00, 0, 0, 2'b00, 0, "R1");               // word -> 7
        one_cycle(1, 2'b10, 2'b00, 0, 0, 2'b00, 0, "R1");               // long -> 3
        one_cycle(1, 2'b11, 2'b00, 0, 0, 2'b00, 0, "R4");               // 3 <= 4 -> 0, terminate
        one_cycle(0, 2'b00, 2'b00, 0, 0, 2'b00, 0, "R4");               // pulse one cycle only
        one_cycle(1, 2'b00, 2'b00, 0, 0, 2'b00, 0, "R2");               // zero holds
        one_cycle(1, 2'b10, 2'b00, 0, 0, 2'b00, 0, "R2");
        one_cycle(0, 2'b00, 2'b00, 1, 0, 2'b11, 32'd2, "R9");           // arm with 2
        one_cycle(1, 2'b01, 2'b00, 1, 0, 2'b11, 32'h100, "R4");         // final step vs CPU write
        one_cycle(0, 2'b00, 2'b00, 0, 0, 2'b00, 0, "R4");
        one_cycle(1, 2'b00, 2'b00, 1, 0, 2'b11, 32'h50, "R3");          // collision, not final
        one_cycle(1, 2'b00, 2'b00, 1, 0, 2'b10, 32'h0001_ABCD, "R3");   // upper lane only
        one_cycle(1, 2'b01, 2'b00, 1, 0, 2'b01, 32'hFFFF_0033, "R3");   // lower lane only
        one_cycle(0, 2'b00, 2'b00, 1, 0, 2'b11, 32'd0, "R9");           // disarm
        one_cycle(0, 2'b00, 2'b01, 1, 1, 2'b11, 32'h0003_0003, "R5");
        one_cycle(1, 2'b00, 2'b01, 0, 0, 2'b00, 0, "R6");
        one_cycle(1, 2'b10, 2'b01, 0, 0, 2'b00, 0, "R6");
        one_cycle(1, 2'b00, 2'b01, 0, 0, 2'b00, 0, "R7");               // reload to 3
        one_cycle(1, 2'b00, 2'b10, 0, 0, 2'b00, 0, "R6");               // repeat mode
        one_cycle(1, 2'b00, 2'b10, 0, 0, 2'b00, 0, "R6");
        one_cycle(1, 2'b00, 2'b10, 0, 0, 2'b00, 0, "R7");
        one_cycle(1, 2'b00, 2'b00, 0, 0, 2'b00, 0, "R8");               // normal mode
        one_cycle(1, 2'b01, 2'b11, 0, 0, 2'b00, 0, "R8");               // spare mode
        one_cycle(1, 2'b00, 2'b01, 1, 1, 2'b10, 32'h0007_FFFF, "R5");   // upper write while counting
        one_cycle(1, 2'b00, 2'b01, 0, 0, 2'b00, 0, "R6");
        one_cycle(1, 2'b00, 2'b01, 1, 1, 2'b01, 32'h0000_0009, "R7");   // reload vs lower write
        one_cycle(0, 2'b00, 2'b01, 1, 1, 2'b01, 32'h0000_0000, "R5");   // lower to 0
        one_cycle(1, 2'b00, 2'b01, 0, 0, 2'b00, 0, "R7");               // zero lower reloads
        one_cycle(1, 2'b00, 2'b01, 1, 0, 2'b11, 32'h1234, "R3");        // both registers busy
        apply_reset();                                                  // R10 mid-run
        @(negedge clk);
        @(negedge clk);
        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule